// File: doc/BRIEF.md
# Micro-Operation Codeword Sequencer

This block sits between an event timing stage and a pulse playback unit. Each trigger carries a micro-operation identifier. The block turns that identifier into a timed train of codeword strobes. The train comes from a small programmable store. Every slot of the store holds up to four steps, and each step is a delay paired with a codeword, plus a length that says how many steps are live. The first codeword of a train leaves after a fixed pipeline latency. Each later codeword follows its predecessor after that step's own delay, counted in clock cycles.

A configuration bit switches the block into a pass-through mode for primitive operations. In that mode the identifier itself is sent out as the codeword, with exactly the same latency as the first step of a train. A host loads steps and lengths through a simple write port. While a multi-step train is running, the block accepts no further triggers. A trigger that arrives in that window is discarded and reported on a one-cycle error strobe.

The control core is a two-state machine. `ENG_IDLE` waits for triggers. `ENG_COUNT` times the gaps of a running train. The transitions are:
- *launch* (`ENG_IDLE` to `ENG_COUNT`): a sequence-mode trigger hits a slot whose length is two or more.
- *hold* (`ENG_IDLE` to `ENG_IDLE`): no trigger, a bypass trigger, a one-step slot or an undefined slot.
- *tick* (`ENG_COUNT` to `ENG_COUNT`): the gap counter runs down, or a step that is not the last is emitted.
- *finish* (`ENG_COUNT` to `ENG_IDLE`): the last step is emitted.

Top module: `uop_codeword_sequencer`

## Requirements
- R1: After reset, `cw_valid` and `overlap_err` are low and every slot is undefined, that is, its length is 0.
- R2: A step write stores a delay and a codeword at (`host_slot`, `host_step`). A length write stores `host_len` for `host_slot`. A length above 4 is kept as 4, and writing 0 makes the slot undefined again.
- R3: In sequence mode (`bypass_en`=0), a trigger sampled at rising edge E on an idle block with a defined slot `trig_id` puts step 0's codeword on `cw_out`, with `cw_valid` high, in the cycle after edge E+LATENCY-1 (E+2 by default). The stored delay of step 0 plays no part.
- R4: Step i≥1 of a train is emitted d_i edges after step i-1, where d_i is the step's stored delay. A stored delay of 0 on a later step acts as 1.
- R5: Each step gives exactly one strobe that is one cycle wide. A train of length n (after clamping) gives n strobes and no others.
- R6: A sequence-mode trigger on an undefined slot produces no strobe and no error.
- R7: With `bypass_en`=1, each trigger on an idle block emits `trig_id` unchanged as the 3-bit codeword, at the latency of R3. Triggers on consecutive cycles each give their own strobe.
- R8: The block is busy from the edge that launches a train of two or more steps up to and including the edge that emits its last step. A trigger sampled while busy, in either mode, is dropped. It raises `overlap_err` for the one cycle after that edge and leaves the running train unchanged. A trigger one edge after the last emission is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Micro-operation trigger strobe |
| trig_id | input | 3 | Micro-operation identifier (slot number) |
| bypass_en | input | 1 | 1: forward the identifier as the codeword |
| host_step_we | input | 1 | Step write strobe |
| host_len_we | input | 1 | Length write strobe |
| host_slot | input | 3 | Slot addressed by a host write |
| host_step | input | 2 | Step index for a step write |
| host_delay | input | 4 | Step delay in cycles |
| host_cw | input | 3 | Step codeword |
| host_len | input | 3 | Slot length, 0 to 4 (larger values are kept as 4) |
| cw_valid | output | 1 | Codeword strobe, one cycle per step |
| cw_out | output | 3 | Codeword emitted with `cw_valid` |
| overlap_err | output | 1 | One-cycle strobe: a trigger was dropped while busy |

## Verification
The hardest case to reach is a trigger that lands exactly on the edge that emits the last step of a train. One edge later the same trigger must be accepted. To get there, the bench launches a two-step slot with a gap of four. It then places triggers two and four edges after the launch, and a third one edge after the last emission. It checks that the first two set the error strobe and the third produces its own strobe. Zero-delay later steps and clamped lengths are reached by loading every slot with delays drawn arithmetically from the range 0 to 4 and sweeping all eight slots.

// File: rtl/uopseq_pkg.sv
`timescale 1ns/1ps
package uopseq_pkg;

    // Sequencing engine states
    typedef enum logic [0:0] {
        ENG_IDLE  = 1'b0,   // waiting for a trigger
        ENG_COUNT = 1'b1    // timing the gap before the next step
    } eng_state_t;

endpackage

// File: rtl/uopseq_store.sv
`timescale 1ns/1ps
// Programmable step store: per slot, N_STEP (delay, codeword) steps plus a length.
module uopseq_store #(
    parameter int N_SLOT = 8,
    parameter int N_STEP = 4,
    parameter int CW_W   = 3,
    parameter int DLY_W  = 4,
    parameter int ID_W   = 3,
    parameter int IDX_W  = 2,
    parameter int LEN_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_we,
    input  logic             len_we,
    input  logic [ID_W-1:0]  wr_slot,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [CW_W-1:0]  wr_cw,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [ID_W-1:0]  rd_slot,
    input  logic [IDX_W-1:0] rd_cw_idx,
    input  logic [IDX_W-1:0] rd_dly_idx,
    output logic [LEN_W-1:0] rd_len,
    output logic [CW_W-1:0]  rd_cw,
    output logic [DLY_W-1:0] rd_dly
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(N_STEP);

    logic [DLY_W-1:0] dly_mem [N_SLOT][N_STEP];
    logic [CW_W-1:0]  cw_mem  [N_SLOT][N_STEP];
    logic [LEN_W-1:0] len_mem [N_SLOT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOT; s++) begin
                len_mem[s] <= '0;
                for (int i = 0; i < N_STEP; i++) begin
                    dly_mem[s][i] <= '0;
                    cw_mem[s][i]  <= '0;
                end
            end
        end else begin
            if (step_we) begin
                dly_mem[wr_slot][wr_idx] <= wr_dly;
                cw_mem[wr_slot][wr_idx]  <= wr_cw;
            end
            if (len_we) begin
                len_mem[wr_slot] <= (wr_len > LEN_MAX) ? LEN_MAX : wr_len;
            end
        end
    end

    assign rd_len = len_mem[rd_slot];
    assign rd_cw  = cw_mem[rd_slot][rd_cw_idx];
    assign rd_dly = dly_mem[rd_slot][rd_dly_idx];

    // R2: no slot ever reports more steps than it can hold
    assert_len_clamped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_len <= LEN_MAX);

endmodule

// File: rtl/uopseq_engine.sv
`timescale 1ns/1ps
// Two-state sequencing engine: launches trains, times step gaps, handles bypass and overlap.
module uopseq_engine
    import uopseq_pkg::*;
#(
    parameter int ID_W  = 3,
    parameter int IDX_W = 2,
    parameter int LEN_W = 3,
    parameter int CW_W  = 3,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid,
    input  logic [ID_W-1:0]  trig_id,
    input  logic             bypass_en,
    input  logic [LEN_W-1:0] cur_len,
    input  logic [CW_W-1:0]  cur_cw,
    input  logic [DLY_W-1:0] nxt_dly,
    output logic [ID_W-1:0]  look_slot,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             busy,
    output logic             raw_v,
    output logic [CW_W-1:0]  raw_cw,
    output logic             ovl_err
);

    eng_state_t       state_q, state_d;
    logic [ID_W-1:0]  slot_q;
    logic [IDX_W-1:0] idx_q;
    logic [DLY_W-1:0] cnt_q;

    logic             accept, start_seq, fire_now, last_step;
    logic [DLY_W-1:0] reload;

    // The store is read at the triggering slot when idle, at the running slot otherwise
    assign look_slot = (state_q == ENG_IDLE) ? trig_id : slot_q;
    assign cur_idx   = (state_q == ENG_IDLE) ? '0 : idx_q;
    assign nxt_idx   = cur_idx + IDX_W'(1);

    assign busy      = (state_q == ENG_COUNT);
    assign accept    = trig_valid && (state_q == ENG_IDLE);
    assign start_seq = accept && !bypass_en && (cur_len != '0);
    assign fire_now  = (state_q == ENG_COUNT) && (cnt_q == DLY_W'(1));
    assign last_step = ((LEN_W'(idx_q) + LEN_W'(1)) == cur_len);
    assign reload    = (nxt_dly == '0) ? DLY_W'(1) : nxt_dly;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (start_seq && (cur_len > LEN_W'(1))) state_d = ENG_COUNT;  // launch
            end
            ENG_COUNT: begin
                if (fire_now && last_step) state_d = ENG_IDLE;                // finish
            end
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            raw_v   <= 1'b0;
            raw_cw  <= '0;
            ovl_err <= 1'b0;
        end else begin
            raw_v   <= 1'b0;
            ovl_err <= trig_valid && (state_q == ENG_COUNT);
            unique case (state_q)
                ENG_IDLE: begin
                    if (accept && bypass_en) begin
                        raw_v  <= 1'b1;
                        raw_cw <= CW_W'(trig_id);
                    end else if (start_seq) begin
                        raw_v  <= 1'b1;
                        raw_cw <= cur_cw;
                        slot_q <= trig_id;
                        idx_q  <= IDX_W'(1);
                        cnt_q  <= reload;
                    end
                end
                ENG_COUNT: begin
                    if (fire_now) begin
                        raw_v  <= 1'b1;
                        raw_cw <= cur_cw;
                        idx_q  <= idx_q + IDX_W'(1);
                        cnt_q  <= reload;
                    end else begin
                        cnt_q  <= cnt_q - DLY_W'(1);
                    end
                end
            endcase
        end
    end

    // R4: a running train always has a live gap counter
    assert_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    // R4: a running train never points past its stored length
    assert_idx_in_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (LEN_W'(idx_q) < cur_len));

    // R8: a dropped trigger does not retarget the running train
    assert_drop_keeps_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && busy) |=> $stable(slot_q));

endmodule

// File: rtl/uopseq_delay_line.sv
`timescale 1ns/1ps
// Fixed-depth register pipeline that sets the trigger-to-codeword latency.
module uopseq_delay_line #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_d,
    output logic [W-1:0] out_d
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign out_d = in_d;
        end else begin : g_pipe
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= in_d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign out_d = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/uop_codeword_sequencer.sv
`timescale 1ns/1ps
module uop_codeword_sequencer #(
    parameter int N_SLOT  = 8,
    parameter int N_STEP  = 4,
    parameter int CW_W    = 3,
    parameter int DLY_W   = 4,
    parameter int LATENCY = 3,
    localparam int ID_W   = $clog2(N_SLOT),
    localparam int IDX_W  = $clog2(N_STEP),
    localparam int LEN_W  = $clog2(N_STEP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid,
    input  logic [ID_W-1:0]  trig_id,
    input  logic             bypass_en,
    input  logic             host_step_we,
    input  logic             host_len_we,
    input  logic [ID_W-1:0]  host_slot,
    input  logic [IDX_W-1:0] host_step,
    input  logic [DLY_W-1:0] host_delay,
    input  logic [CW_W-1:0]  host_cw,
    input  logic [LEN_W-1:0] host_len,
    output logic             cw_valid,
    output logic [CW_W-1:0]  cw_out,
    output logic             overlap_err
);

    localparam int PIPE = LATENCY - 1;

    logic [ID_W-1:0]  look_slot;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic [LEN_W-1:0] slot_len;
    logic [CW_W-1:0]  slot_cw;
    logic [DLY_W-1:0] slot_dly;
    logic             busy, raw_v;
    logic [CW_W-1:0]  raw_cw;

    uopseq_store #(
        .N_SLOT(N_SLOT), .N_STEP(N_STEP), .CW_W(CW_W), .DLY_W(DLY_W),
        .ID_W(ID_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_we    (host_step_we),
        .len_we     (host_len_we),
        .wr_slot    (host_slot),
        .wr_idx     (host_step),
        .wr_dly     (host_delay),
        .wr_cw      (host_cw),
        .wr_len     (host_len),
        .rd_slot    (look_slot),
        .rd_cw_idx  (cur_idx),
        .rd_dly_idx (nxt_idx),
        .rd_len     (slot_len),
        .rd_cw      (slot_cw),
        .rd_dly     (slot_dly)
    );

    uopseq_engine #(
        .ID_W(ID_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .CW_W(CW_W), .DLY_W(DLY_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_valid (trig_valid),
        .trig_id    (trig_id),
        .bypass_en  (bypass_en),
        .cur_len    (slot_len),
        .cur_cw     (slot_cw),
        .nxt_dly    (slot_dly),
        .look_slot  (look_slot),
        .cur_idx    (cur_idx),
        .nxt_idx    (nxt_idx),
        .busy       (busy),
        .raw_v      (raw_v),
        .raw_cw     (raw_cw),
        .ovl_err    (overlap_err)
    );

    uopseq_delay_line #(
        .W(CW_W + 1), .DEPTH(PIPE)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .in_d  ({raw_v, raw_cw}),
        .out_d ({cw_valid, cw_out})
    );

    // R7: an idle bypass trigger is forwarded as the codeword
    assert_bypass_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trig_valid && bypass_en && !busy))
        |-> (raw_v && (raw_cw == CW_W'($past(trig_id)))));

    // R3: an accepted train starts with step 0 of the addressed slot
    assert_first_cw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trig_valid && !bypass_en && !busy && (slot_len != '0)))
        |-> (raw_v && (raw_cw == $past(slot_cw))));

    // R6: an undefined slot stays silent
    assert_undefined_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trig_valid && !bypass_en && !busy && (slot_len == '0)))
        |-> !raw_v);

    // R8: the error strobe has a trigger behind it
    assert_overlap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |-> $past(trig_valid));

endmodule

// File: tb/uop_codeword_sequencer_test.sv
`timescale 1ns/1ps
module uop_codeword_sequencer_test;

    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_valid = 1'b0;
    logic [2:0] trig_id = '0;
    logic       bypass_en = 1'b0;
    logic       host_step_we = 1'b0;
    logic       host_len_we = 1'b0;
    logic [2:0] host_slot = '0;
    logic [1:0] host_step = '0;
    logic [3:0] host_delay = '0;
    logic [2:0] host_cw = '0;
    logic [2:0] host_len = '0;
    logic       cw_valid;
    logic [2:0] cw_out;
    logic       overlap_err;

    uop_codeword_sequencer uut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_id(trig_id),
        .bypass_en(bypass_en), .host_step_we(host_step_we), .host_len_we(host_len_we),
        .host_slot(host_slot), .host_step(host_step), .host_delay(host_delay),
        .host_cw(host_cw), .host_len(host_len), .cw_valid(cw_valid), .cw_out(cw_out),
        .overlap_err(overlap_err)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int log_t [64];
    int log_cw [64];
    int log_n = 0;
    int err_n = 0;

    int m_len [8];
    int m_dly [8][4];
    int m_cw  [8][4];

    always @(negedge clk) begin
        if (cw_valid && log_n < 64) begin
            log_t[log_n]  = cyc;
            log_cw[log_n] = int'(cw_out);
            log_n = log_n + 1;
        end
        if (overlap_err) err_n = err_n + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0;
        err_n = 0;
    endtask

    task automatic wr_step(input int s, input int i, input int d, input int c);
        @(negedge clk);
        host_step_we = 1'b1; host_slot = 3'(s); host_step = 2'(i);
        host_delay = 4'(d); host_cw = 3'(c);
        @(negedge clk);
        host_step_we = 1'b0;
        m_dly[s][i] = d;
        m_cw[s][i]  = c;
    endtask

    task automatic wr_len(input int s, input int l);
        @(negedge clk);
        host_len_we = 1'b1; host_slot = 3'(s); host_len = 3'(l);
        @(negedge clk);
        host_len_we = 1'b0;
        m_len[s] = l;
    endtask

    // Drive one trigger; e returns the edge number that samples it
    task automatic fire(input int id, output int e);
        @(negedge clk);
        trig_valid = 1'b1; trig_id = 3'(id); e = cyc + 1;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    // Trigger a slot in sequence mode and compare the train against the stored program
    task automatic run_slot(input int s);
        int e, ln, t;
        clear_log();
        fire(s, e);
        repeat (30) @(negedge clk);
        ln = (m_len[s] > 4) ? 4 : m_len[s];
        if (ln == 0) chk("R6 undefined slot strobe count", log_n, 0);
        else         chk("R5 strobe count", log_n, ln);
        chk("R6/R8 no error strobe", err_n, 0);
        t = e + LAT - 1;
        for (int i = 0; i < ln && i < log_n; i++) begin
            if (i > 0) t = t + ((m_dly[s][i] == 0) ? 1 : m_dly[s][i]);
            if (i == 0) begin
                chk("R3 first step cycle", log_t[i], t);
                chk("R3 first step codeword", log_cw[i], m_cw[s][0]);
            end else begin
                chk("R4 step cycle", log_t[i], t);
                chk("R4 step codeword", log_cw[i], m_cw[s][i]);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int e;
        for (int s = 0; s < 8; s++) begin
            m_len[s] = 0;
            for (int i = 0; i < 4; i++) begin
                m_dly[s][i] = 0;
                m_cw[s][i]  = 0;
            end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cw_valid after reset", int'(cw_valid), 0);
        chk("R1 overlap_err after reset", int'(overlap_err), 0);

        // R1/R6: every slot starts undefined
        for (int s = 0; s < 8; s++) run_slot(s);

        // R2: program all slots; later-step delays include 0, slot 6 is clamped, slot 7 stays empty
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < 4; i++) wr_step(s, i, (s + 3 * i) % 5, (s * 5 + i * 3) % 8);
            if (s < 6)       wr_len(s, (s % 4) + 1);
            else if (s == 6) wr_len(s, 7);
            else             wr_len(s, 0);
        end
        // slot 1: two-step example, codeword 1 then codeword 4 after four cycles
        wr_step(1, 0, 0, 1);
        wr_step(1, 1, 4, 4);
        wr_len(1, 2);

        for (int s = 0; s < 8; s++) run_slot(s);

        // R7: bypass sweep, one trigger per cycle
        bypass_en = 1'b1;
        clear_log();
        @(negedge clk);
        e = cyc + 1;
        for (int k = 0; k < 8; k++) begin
            trig_valid = 1'b1; trig_id = 3'(k);
            @(negedge clk);
        end
        trig_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk("R7 bypass strobe count", log_n, 8);
        for (int k = 0; k < 8 && k < log_n; k++) begin
            chk("R7 bypass cycle", log_t[k], e + k + LAT - 1);
            chk("R7 bypass codeword", log_cw[k], k);
        end
        bypass_en = 1'b0;

        // R8: overlap on a running train, on its last-emission edge, then acceptance one edge later
        clear_log();
        @(negedge clk);
        trig_valid = 1'b1; trig_id = 3'd1; e = cyc + 1;
        @(negedge clk);                       // cyc = e
        trig_valid = 1'b0;
        @(negedge clk);                       // cyc = e+1
        trig_valid = 1'b1; trig_id = 3'd3;    // sampled at e+2
        @(negedge clk);                       // cyc = e+2
        trig_valid = 1'b0;
        chk("R8 overlap_err mid train", int'(overlap_err), 1);
        @(negedge clk);                       // cyc = e+3
        trig_valid = 1'b1; trig_id = 3'd2;    // sampled at e+4, last emission edge
        @(negedge clk);                       // cyc = e+4
        chk("R8 overlap_err on last edge", int'(overlap_err), 1);
        trig_id = 3'd0;                       // sampled at e+5, must be accepted
        @(negedge clk);                       // cyc = e+5
        trig_valid = 1'b0;
        chk("R8 accepted after finish", int'(overlap_err), 0);
        repeat (12) @(negedge clk);
        chk("R8 strobe count", log_n, 3);
        chk("R8 error strobe count", err_n, 2);
        if (log_n == 3) begin
            chk("R8 step0 cycle", log_t[0], e + LAT - 1);
            chk("R8 step0 codeword", log_cw[0], 1);
            chk("R8 step1 cycle", log_t[1], e + 4 + LAT - 1);
            chk("R8 step1 codeword", log_cw[1], 4);
            chk("R8 next train cycle", log_t[2], e + 5 + LAT - 1);
            chk("R8 next train codeword", log_cw[2], m_cw[0][0]);
        end

        // R2: writing length 0 undefines a slot again
        wr_len(2, 0);
        run_slot(2);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule